// File: doc/BRIEF.md
# Bipolar Line Decoder with Code Violation Counter

This block sits behind a line receiver that delivers a received bipolar signal as two rails, one for positive marks and one for negative marks, together with a clock enable that pulses once per bit period. It turns the ternary symbol stream back into a single NRZ data bit, using one of three line codes: plain alternate mark inversion, the four-zero substitution code used on E1 links, or the eight-zero substitution code used on T1/J1 links. A legal substitution pattern in the received stream is rewritten as the run of zeros it stands for. The violations that belong to such a pattern are never reported.

Every other code violation is flagged on the output alongside the bit it concerns, and is added to a saturating 16-bit counter. A host strobe transfers the live count into a read register and restarts the counter in the same cycle. The decoder holds a fixed delay line, so that a pattern can be recognised when its last symbol arrives and the symbols already taken in can still be rewritten.

Top module: `bpd_line_decoder`

## Requirements
- R1: `code_sel` selects the line code (0 = AMI, 1 = HDB3, 2 = B8ZS, 3 behaves as AMI). A set `rail_p` alone is a positive mark, a set `rail_n` alone is a negative mark, and both low is a space. A mark is decoded as a one. A symbol accepted on bit-enable edge k appears on `nrz_data` after bit-enable edge k+4 in AMI and HDB3, and after edge k+8 in B8ZS. Before the line fills, the output is zero.
- R2: In HDB3, a mark with the same polarity as the previous mark is a violation V. When it follows two spaces and the symbol before those is not a dual-rail symbol (patterns 000V and B00V), all four symbols are output as zeros and V is not counted.
- R3: In B8ZS, the eight symbols 0,0,0,V,B,0,V,B (V with the polarity of the mark before it, then marks alternating as ~V, ~V... so that the pattern is X,~X,~X,X for the four marks) are output as eight zeros, and neither V is counted.
- R4: A mark with the same polarity as the previous mark is counted as a violation when it is not part of a legal pattern. The polarity tracker starts at positive, and the first mark after reset is never a violation.
- R5: A symbol with both rails set is decoded as a one and counted. It leaves the mark polarity unchanged.
- R6: In HDB3, a substitution whose V has the same polarity as the V of the previous recognised substitution is still output as four zeros, but it is counted once. The first substitution after reset is never counted this way.
- R7: In HDB3 with `ext_zero_chk` set, the fourth consecutive space of a run is counted once per run. The flag is cleared by a mark or a dual-rail symbol. In other modes, or with the flag clear, runs of spaces are not counted.
- R8: `cv_flag` is high for exactly one clock, after the bit-enable edge that moves a counted symbol onto `nrz_data`. The live counter increments on that same edge.
- R9: The live counter saturates at 16'hFFFF and does not wrap.
- R10: A `cnt_latch` pulse copies the live count into `cnt_value` and clears the live counter on the same edge. An increment in that cycle leaves the live counter at 1. `cnt_value` changes only on a latch, and resets to 0.
- R11: The decoder state and `nrz_data` change only on clock edges where `bit_en` is high.
- R12: In HDB3 and B8ZS, a same-polarity mark that does not complete a legal pattern is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle pulse per received bit period |
| rail_p | input | 1 | Positive-mark rail from the line receiver |
| rail_n | input | 1 | Negative-mark rail from the line receiver |
| code_sel | input | 2 | Line code: 0 AMI, 1 HDB3, 2 B8ZS, 3 as AMI |
| ext_zero_chk | input | 1 | HDB3 only: also count runs of four spaces |
| cnt_latch | input | 1 | Host strobe: copy live count to read register and clear |
| nrz_data | output | 1 | Decoded data bit |
| cv_flag | output | 1 | Pulse marking a counted code violation on the current bit |
| cnt_value | output | CNT_W | Count captured by the last latch strobe |

## Verification
The two functions that can meet in one clock are a host latch and a counter increment: a latch strobe can coincide with the bit-enable edge that exports a counted violation. The random streams place latch pulses on both idle and bit-enable cycles. A directed step latches while a saturated AMI violation stream is still flowing, then latches again on an idle cycle. The first read must show 16'hFFFF and the second read must show 1, which proves the coincident increment survived the clear. A bench model of the count and read register follows every cycle and judges each latched value.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

    typedef enum logic [1:0] {
        LC_AMI  = 2'd0,
        LC_HDB3 = 2'd1,
        LC_B8ZS = 2'd2,
        LC_RSVD = 2'd3
    } lcode_e;

    // One received symbol in the delay line: raw rails plus decoded view
    typedef struct packed {
        logic p;
        logic n;
        logic one;
        logic viol;
    } slot_t;

    localparam int HDB3_SPAN  = 4;
    localparam int B8ZS_SPAN  = 8;
    localparam int ZRUN_LIMIT = 4;

endpackage

// File: rtl/bpd_pol_track.sv
module bpd_pol_track
    import bpd_pkg::*;
#(
    parameter int ZRUN_MAX = ZRUN_LIMIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rail_p,
    input  logic rail_n,
    output logic sym_mark,
    output logic sym_both,
    output logic sym_bpv,
    output logic zrun_hit
);

    localparam int ZW = $clog2(ZRUN_MAX + 1);

    typedef struct packed {
        logic          last_neg;
        logic          seen;
        logic [ZW-1:0] zrun;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        sym_both = rail_p & rail_n;
        sym_mark = rail_p ^ rail_n;
        sym_bpv  = sym_mark & st_q.seen & (rail_n == st_q.last_neg);
        zrun_hit = ~rail_p & ~rail_n & (st_q.zrun == ZW'(ZRUN_MAX - 1));
        if (bit_en) begin
            if (sym_mark) begin
                st_d.last_neg = rail_n;
                st_d.seen     = 1'b1;
                st_d.zrun     = '0;
            end else if (sym_both) begin
                st_d.zrun = '0;
            end else if (st_q.zrun != ZW'(ZRUN_MAX)) begin
                st_d.zrun = st_q.zrun + ZW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bpd_sub_line.sv
module bpd_sub_line
    import bpd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bit_en,
    input  lcode_e code,
    input  logic   ext_chk,
    input  logic   rail_p,
    input  logic   rail_n,
    input  logic   sym_mark,
    input  logic   sym_both,
    input  logic   sym_bpv,
    input  logic   zrun_hit,
    output logic   cv_evt,
    output logic   nrz_q,
    output logic   cv_q
);

    localparam int DEPTH = B8ZS_SPAN;

    typedef struct packed {
        slot_t [DEPTH-1:0] line;
        logic              have_v;
        logic              lastv_neg;
        logic              nrz;
        logic              cv;
    } line_st_t;

    line_st_t st_d, st_q;

    slot_t             fresh;
    slot_t             tap;
    slot_t [DEPTH-1:0] nl;
    logic              hdb_hit;
    logic              b8_hit;

    function automatic logic is_space(slot_t s);
        return ~s.p & ~s.n;
    endfunction

    function automatic logic is_mk(slot_t s, logic neg);
        return (s.p ^ s.n) & (s.n == neg);
    endfunction

    always_comb begin
        st_d    = st_q;
        st_d.cv = 1'b0;

        fresh.p    = rail_p;
        fresh.n    = rail_n;
        fresh.one  = rail_p | rail_n;
        fresh.viol = sym_both | sym_bpv
                   | ((code == LC_HDB3) & ext_chk & zrun_hit);

        tap    = (code == LC_B8ZS) ? st_q.line[B8ZS_SPAN-1] : st_q.line[HDB3_SPAN-1];
        cv_evt = bit_en & tap.viol;

        hdb_hit = (code == LC_HDB3) & sym_mark & sym_bpv
                & is_space(st_q.line[0]) & is_space(st_q.line[1])
                & ~(st_q.line[2].p & st_q.line[2].n);

        b8_hit = (code == LC_B8ZS) & sym_mark
               & is_mk(st_q.line[0], ~rail_n) & is_space(st_q.line[1])
               & is_mk(st_q.line[2], ~rail_n) & is_mk(st_q.line[3], rail_n)
               & is_space(st_q.line[4]) & is_space(st_q.line[5])
               & is_space(st_q.line[6]);

        nl[0] = fresh;
        for (int i = 1; i < DEPTH; i++) begin
            nl[i] = st_q.line[i-1];
        end

        if (hdb_hit) begin
            for (int i = 0; i < HDB3_SPAN; i++) begin
                nl[i].one = 1'b0;
            end
            nl[0].viol = st_q.have_v & (st_q.lastv_neg == rail_n);
        end

        if (b8_hit) begin
            for (int i = 0; i < B8ZS_SPAN; i++) begin
                nl[i].one = 1'b0;
            end
            nl[1].viol = 1'b0;
            nl[4].viol = 1'b0;
        end

        if (bit_en) begin
            st_d.nrz  = tap.one;
            st_d.cv   = tap.viol;
            st_d.line = nl;
            if (hdb_hit) begin
                st_d.have_v    = 1'b1;
                st_d.lastv_neg = rail_n;
            end
        end

        nrz_q = st_q.nrz;
        cv_q  = st_q.cv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bpd_cv_count.sv
module bpd_cv_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             latch,
    output logic [CNT_W-1:0] cnt_live,
    output logic [CNT_W-1:0] cnt_rd
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] live;
        logic [CNT_W-1:0] rd;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (latch) begin
            st_d.rd   = st_q.live;
            st_d.live = inc ? CNT_W'(1) : '0;
        end else if (inc && (st_q.live != CNT_MAX)) begin
            st_d.live = st_q.live + CNT_W'(1);
        end
        cnt_live = st_q.live;
        cnt_rd   = st_q.rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bpd_line_decoder.sv
module bpd_line_decoder
    import bpd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rail_p,
    input  logic             rail_n,
    input  logic [1:0]       code_sel,
    input  logic             ext_zero_chk,
    input  logic             cnt_latch,
    output logic             nrz_data,
    output logic             cv_flag,
    output logic [CNT_W-1:0] cnt_value
);

    logic             sym_mark;
    logic             sym_both;
    logic             sym_bpv;
    logic             zrun_hit;
    logic             cv_evt;
    logic [CNT_W-1:0] cnt_live;
    lcode_e           code;

    assign code = lcode_e'(code_sel);

    bpd_pol_track #(
        .ZRUN_MAX (ZRUN_LIMIT)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .rail_p   (rail_p),
        .rail_n   (rail_n),
        .sym_mark (sym_mark),
        .sym_both (sym_both),
        .sym_bpv  (sym_bpv),
        .zrun_hit (zrun_hit)
    );

    bpd_sub_line u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .code     (code),
        .ext_chk  (ext_zero_chk),
        .rail_p   (rail_p),
        .rail_n   (rail_n),
        .sym_mark (sym_mark),
        .sym_both (sym_both),
        .sym_bpv  (sym_bpv),
        .zrun_hit (zrun_hit),
        .cv_evt   (cv_evt),
        .nrz_q    (nrz_data),
        .cv_q     (cv_flag)
    );

    bpd_cv_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (cv_evt),
        .latch    (cnt_latch),
        .cnt_live (cnt_live),
        .cnt_rd   (cnt_value)
    );

endmodule

// File: rtl/bpd_line_decoder_chk.sv
module bpd_line_decoder_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             cnt_latch,
    input logic             nrz_data,
    input logic             cv_flag,
    input logic [CNT_W-1:0] cnt_value,
    input logic [CNT_W-1:0] cnt_live
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R8: a violation pulse only follows a bit-enable edge
    p_cv_on_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cv_flag |-> $past(bit_en));

    // R8: without a latch, the live count moves by exactly the pulse
    p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_latch) && ($past(cnt_live) != CNT_MAX))
        |-> (cnt_live == ($past(cnt_live) + CNT_W'(cv_flag))));

    // R9: a saturated count stays saturated
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_latch) && ($past(cnt_live) == CNT_MAX))
        |-> (cnt_live == CNT_MAX));

    // R10: a latch copies the live count and restarts it
    p_latch_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_latch)
        |-> ((cnt_value == $past(cnt_live)) && (cnt_live <= CNT_W'(1))));

    // R10: the read register changes only on a latch
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cnt_latch) |-> $stable(cnt_value));

    // R11: no bit enable, no change of the data output
    p_nrz_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> $stable(nrz_data));

endmodule

bind bpd_line_decoder bpd_line_decoder_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .cnt_latch (cnt_latch),
    .nrz_data  (nrz_data),
    .cv_flag   (cv_flag),
    .cnt_value (cnt_value),
    .cnt_live  (cnt_live)
);

// File: tb/bpd_line_decoder_tb_top.sv
module bpd_line_decoder_tb_top;

    localparam int MAXN = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        rail_p = 1'b0;
    logic        rail_n = 1'b0;
    logic [1:0]  code_sel = 2'd0;
    logic        ext_zero_chk = 1'b0;
    logic        cnt_latch = 1'b0;
    logic        nrz_data;
    logic        cv_flag;
    logic [15:0] cnt_value;

    bpd_line_decoder #(.CNT_W(16)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .rail_p       (rail_p),
        .rail_n       (rail_n),
        .code_sel     (code_sel),
        .ext_zero_chk (ext_zero_chk),
        .cnt_latch    (cnt_latch),
        .nrz_data     (nrz_data),
        .cv_flag      (cv_flag),
        .cnt_value    (cnt_value)
    );

    always #4 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    bit sp [0:MAXN-1];
    bit sn [0:MAXN-1];
    bit e_one [0:MAXN-1];
    bit e_viol [0:MAXN-1];
    int nsym;
    bit g_last;

    logic        m_nrz;
    logic [15:0] m_cnt;
    logic [15:0] m_rd;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic add(input bit p, input bit n);
        sp[nsym] = p;
        sn[nsym] = n;
        nsym++;
    endtask

    task automatic add_mark(input bit neg);
        add(!neg, neg);
        g_last = neg;
    endtask

    function automatic bit zr(input int k);
        if (k < 0) return 1'b1;
        return !sp[k] && !sn[k];
    endfunction

    function automatic bit mk(input int k, input bit neg);
        if (k < 0) return 1'b0;
        return (sp[k] ^ sn[k]) && (sn[k] == neg);
    endfunction

    // Expected decode of the whole stream, from the requirements
    task automatic build_model(input int mode, input bit ext);
        bit last_neg = 0, seen = 0, havev = 0, lastv = 0;
        int zrun = 0;
        for (int i = 0; i < nsym; i++) begin
            bit p = sp[i], n = sn[i], bpv = 0, hit = 0;
            e_one[i]  = p | n;
            e_viol[i] = 0;
            if (p && n) begin
                e_viol[i] = 1;                       // R5
                zrun = 0;
            end else if (p ^ n) begin
                bpv = seen && (n == last_neg);       // R4
                e_viol[i] = bpv;
                last_neg = n;
                seen = 1;
                zrun = 0;
            end else begin
                hit = (zrun == 3);
                if (zrun < 4) zrun++;
                if (mode == 1 && ext && hit) e_viol[i] = 1;   // R7
            end
            if (mode == 1 && (p ^ n) && bpv && zr(i-1) && zr(i-2)
                && !((i - 3 >= 0) && sp[i-3] && sn[i-3])) begin   // R2
                for (int k = i - 3; k <= i; k++) if (k >= 0) e_one[k] = 0;
                e_viol[i] = havev && (lastv == n);   // R6
                havev = 1;
                lastv = n;
            end
            if (mode == 2 && (p ^ n) && mk(i-1, !n) && zr(i-2) && mk(i-3, !n)
                && mk(i-4, n) && zr(i-5) && zr(i-6) && zr(i-7)) begin   // R3
                for (int k = i - 7; k <= i; k++) if (k >= 0) e_one[k] = 0;
                e_viol[i-1] = 0;
                e_viol[i-4] = 0;
            end
        end
    endtask

    task automatic gen_random(input int mode, input int target);
        nsym = 0;
        g_last = 1;
        while (nsym < target) begin
            int r = $urandom % 16;
            if (r <= 4) add(0, 0);
            else if (r <= 8) add_mark(!g_last);
            else if (r == 9) add_mark(g_last);
            else if (r == 10) add(1, 1);
            else if (r <= 13) begin
                if (mode == 1) begin
                    if ($urandom % 2) begin
                        add(0, 0); add(0, 0); add(0, 0); add_mark(g_last);
                    end else begin
                        add_mark(!g_last); add(0, 0); add(0, 0); add_mark(g_last);
                    end
                end else if (mode == 2) begin
                    bit x = g_last;
                    add(0, 0); add(0, 0); add(0, 0);
                    add_mark(x); add_mark(!x); add(0, 0); add_mark(!x); add_mark(x);
                end else begin
                    add(0, 0); add(0, 0); add(0, 0);
                end
            end else if (r == 14) begin
                for (int k = 0; k < 5; k++) add(0, 0);
            end else begin
                add(0, 0); add_mark(g_last);   // R12: lone violation
            end
        end
    endtask

    task automatic step(input bit en, input bit p, input bit n, input bit lat,
                        input int oidx, input string tag);
        bit inc;
        bit_en = en; rail_p = p; rail_n = n; cnt_latch = lat;
        @(negedge clk);
        inc = en && (oidx >= 0) && e_viol[oidx];
        if (en) m_nrz = (oidx >= 0) ? e_one[oidx] : 1'b0;
        if (lat) begin
            m_rd  = m_cnt;
            m_cnt = inc ? 16'd1 : 16'd0;
        end else if (inc && m_cnt != 16'hFFFF) begin
            m_cnt = m_cnt + 16'd1;
        end
        if (en) check(nrz_data == m_nrz, tag, "nrz_data", nrz_data, m_nrz);
        else    check(nrz_data == m_nrz, "R11", "nrz_data idle", nrz_data, m_nrz);
        check(cv_flag == inc, "R8", "cv_flag", cv_flag, inc);
        if (lat) check(cnt_value == m_rd, "R10", "cnt_value", cnt_value, m_rd);
    endtask

    task automatic do_reset(input int mode, input bit ext);
        bit_en = 0; rail_p = 0; rail_n = 0; cnt_latch = 0;
        rst_n = 0;
        code_sel = 2'(mode);
        ext_zero_chk = ext;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        m_nrz = 0; m_cnt = 0; m_rd = 0;
        check(nrz_data == 0, "R1", "reset nrz_data", nrz_data, 0);
        check(cv_flag == 0, "R8", "reset cv_flag", cv_flag, 0);
        check(cnt_value == 0, "R10", "reset cnt_value", cnt_value, 0);
    endtask

    task automatic run_stream(input int mode, input bit ext, input string tag,
                              input bit gaps);
        int lat_len = (mode == 2) ? 8 : 4;
        do_reset(mode, ext);
        build_model(mode, ext);
        for (int j = 0; j < nsym; j++) begin
            if (gaps) begin
                int idle = $urandom % 3;
                for (int g = 0; g < idle; g++)
                    step(0, $urandom % 2, $urandom % 2, ($urandom % 8) == 0, -1, tag);
            end
            step(1, sp[j], sn[j], ($urandom % 10) == 0, j - lat_len, tag);
        end
        step(0, 0, 0, 1, -1, "R10");
    endtask

    initial begin
        void'($urandom(32'd90210));

        // R4 / R1: AMI, first mark free, repeated polarity counted
        nsym = 0;
        add(1, 0); add(1, 0); add(0, 1); add(0, 0); add(0, 1); add(1, 0);
        for (int k = 0; k < 6; k++) add(0, 0);
        run_stream(0, 0, "R4", 0);

        // R5: dual-rail symbols in each code
        for (int m = 0; m < 3; m++) begin
            nsym = 0;
            add(1, 0); add(1, 1); add(0, 1); add(1, 1); add(1, 0);
            for (int k = 0; k < 9; k++) add(0, 0);
            run_stream(m, 0, "R5", 0);
        end

        // R2 / R6: B00V then 000V repeating V polarity
        nsym = 0; g_last = 0;
        add_mark(0);
        add_mark(1); add(0, 0); add(0, 0); add_mark(1);
        add(0, 0); add(0, 0); add(0, 0); add_mark(1);
        add_mark(0); add(0, 0); add(0, 0); add(0, 0); add_mark(0);
        for (int k = 0; k < 6; k++) add(0, 0);
        run_stream(1, 0, "R6", 1);

        // R7: extended zero-run check, long run counted once
        nsym = 0;
        add(1, 0);
        for (int k = 0; k < 7; k++) add(0, 0);
        add(0, 1); add(0, 0); add(0, 0); add(0, 0); add(1, 1);
        for (int k = 0; k < 5; k++) add(0, 0);
        run_stream(1, 1, "R7", 1);

        // R3: B8ZS pattern after a positive mark, then a broken copy (R12)
        nsym = 0;
        add(1, 0);
        add(0, 0); add(0, 0); add(0, 0); add(1, 0); add(0, 1); add(0, 0); add(0, 1); add(1, 0);
        add(0, 1);
        add(0, 0); add(0, 0); add(0, 1); add(1, 0); add(0, 0); add(0, 0); add(1, 0); add(0, 1);
        for (int k = 0; k < 9; k++) add(0, 0);
        run_stream(2, 0, "R3", 0);

        // Random mixes in every code
        gen_random(0, 600); run_stream(0, 0, "R1/R4", 1);
        gen_random(1, 600); run_stream(1, 0, "R2/R6/R12", 1);
        gen_random(1, 600); run_stream(1, 1, "R2/R7/R12", 1);
        gen_random(2, 600); run_stream(2, 0, "R3/R12", 1);
        gen_random(3, 300); run_stream(3, 0, "R1", 1);

        // R9 / R10: saturation, then latch coinciding with an increment
        do_reset(0, 0);
        for (int k = 0; k < 65545; k++) begin
            bit_en = 1; rail_p = 1; rail_n = 0; cnt_latch = 0;
            @(negedge clk);
        end
        cnt_latch = 1;
        @(negedge clk);
        check(cnt_value == 16'hFFFF, "R9", "saturated count", cnt_value, 16'hFFFF);
        bit_en = 0; cnt_latch = 1;
        @(negedge clk);
        check(cnt_value == 16'd1, "R10", "increment during latch", cnt_value, 1);
        cnt_latch = 0;
        @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule